// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer

This block runs the receive half of a descriptor-driven packet DMA engine. Software programs a ring base address, then issues a start pulse. The sequencer reads word 0 of the descriptor at its current list position over a simple single-beat bus master port and checks the ownership flag in that word. For a descriptor the engine owns, it runs a stub buffer handshake that stands in for the payload transfer. It then writes word 0 back with the ownership flag cleared, which returns the descriptor to software. After that it steps to the next descriptor.

When it meets a descriptor that software still holds, the engine parks in a suspended state and raises a buffer-unavailable flag. A poll-demand pulse makes it retry the same slot. A stop request takes effect at the next descriptor boundary. The list position survives the stop, so a later start continues where the engine left off. Any bus or buffer error response halts the engine. It then reports a fatal flag and two flags that classify the error: whether the failing access was a read, and whether it touched a descriptor.

Top module: `rxRingDma`

## Requirements
- R1: After reset, runState is 0, busReq and bufReq are low, and bufUnavail, fatalErr, errRead and errDesc are all 0. runState encodes 0 = stopped, 1 = running, 2 = suspended.
- R2: A startPulse while stopped moves runState to 1. The first bus request is a read (busWe = 0) at curDesc, which is either the programmed base or the position retained from before.
- R3: When a fetched word 0 has bit 31 (ownership) clear, runState becomes 2 and bufUnavail is set. No further bus or buffer request is made until a poll or stop arrives.
- R4: An owned descriptor gets one bufReq handshake. Word 0 is then written back to the same address with bit 31 cleared and every other bit unchanged. curDesc advances by DESC_WORDS*DATA_W/8 bytes (16 by default), or returns to the base when word 0 bit 30 (ring end) is set.
- R5: A stopPulse takes effect once the descriptor in hand has been handed back, or at once if the engine is suspended. curDesc keeps its value across the stop, and the next start fetches from it.
- R6: A startPulse has no effect while running or suspended.
- R7: baseWr loads baseAddr into both the ring base and curDesc only while stopped. At other times it is ignored.
- R8: A pollDemand pulse while suspended refetches the descriptor at the same curDesc.
- R9: An error response halts the engine (runState 0) and sets fatalErr. A descriptor read sets errRead=1 and errDesc=1. A descriptor writeback sets errRead=0 and errDesc=1. A buffer-stub error sets errRead=0 and errDesc=0. curDesc is left unchanged.
- R10: stsClr clears bufUnavail and fatalErr. errRead and errDesc read 0 whenever fatalErr is 0, and they hold their values while fatalErr stays set.
- R11: busReq, busWe and busAddr stay stable from the start of a request until busAck or busErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Start command, one cycle |
| stopPulse | input | 1 | Stop request, one cycle |
| pollDemand | input | 1 | Retry request for a suspended engine |
| baseWr | input | 1 | Load strobe for the ring base |
| baseAddr | input | ADDR_W | Ring base address |
| stsClr | input | 1 | Clears the status flags |
| busReq | output | 1 | Bus transfer request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Descriptor word address |
| busWdata | output | DATA_W | Writeback data |
| busRdata | input | DATA_W | Read data, valid with busAck |
| busAck | input | 1 | Transfer completed |
| busErr | input | 1 | Transfer failed |
| bufReq | output | 1 | Buffer stub request |
| bufAck | input | 1 | Buffer stub done |
| bufErr | input | 1 | Buffer stub failed |
| runState | output | 2 | 0 stopped, 1 running, 2 suspended |
| curDesc | output | ADDR_W | Current list position |
| bufUnavail | output | 1 | Hit a descriptor not owned by the engine |
| fatalErr | output | 1 | Error response seen |
| errRead | output | 1 | Failing access was a read |
| errDesc | output | 1 | Failing access was a descriptor access |

## Verification
The bench uses random ownership patterns around a wrapping ring, with random bus latency. It targets a design that suspends at the wrong slot, skips the ring-end wrap, or corrupts the non-ownership bits on writeback. Stop-then-start sequences catch an engine that reloads the base on restart instead of keeping its position. A start pulse sent while suspended catches a design that lets that pulse resume it. Errors are injected one at a time on the fetch, the buffer stub and the writeback. Each check confirms that the two type flags select the failing access and that a failed writeback leaves the descriptor owned.

// File: rtl/rxRingPkg.sv
package rxRingPkg;

  typedef enum logic [2:0] {
    PH_STOP,
    PH_FETCH,
    PH_BUF,
    PH_WB,
    PH_SUSP
  } rxPhase_e;

  localparam logic [1:0] RUN_STOPPED   = 2'd0;
  localparam logic [1:0] RUN_ACTIVE    = 2'd1;
  localparam logic [1:0] RUN_SUSPENDED = 2'd2;

  typedef struct packed {
    logic loadBase;
    logic latchWord;
    logic advance;
    logic setUnavail;
    logic setFatal;
    logic errIsRead;
    logic errIsDesc;
    logic clrStatus;
  } rxStrobe_t;

endpackage

// File: rtl/rxRingCtrl.sv
module rxRingCtrl
  import rxRingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       pollDemand,
  input  logic       baseWr,
  input  logic       stsClr,
  input  logic       busAck,
  input  logic       busErr,
  input  logic       rdOwn,
  input  logic       bufAck,
  input  logic       bufErr,
  output logic       busReq,
  output logic       busWe,
  output logic       bufReq,
  output logic [1:0] runState,
  output rxStrobe_t  stb
);

  rxPhase_e phase, nextPhase;
  logic     stopPend;
  logic     stopNow;

  assign stopNow = stopPend | stopPulse;

  always_comb begin
    nextPhase = phase;
    stb       = '0;
    stb.clrStatus = stsClr;
    case (phase)
      PH_STOP: begin
        stb.loadBase = baseWr;
        if (startPulse) nextPhase = PH_FETCH;
      end
      PH_FETCH: begin
        if (busErr) begin
          nextPhase     = PH_STOP;
          stb.setFatal  = 1'b1;
          stb.errIsRead = 1'b1;
          stb.errIsDesc = 1'b1;
        end else if (busAck) begin
          stb.latchWord = 1'b1;
          if (rdOwn) begin
            nextPhase = PH_BUF;
          end else begin
            nextPhase      = PH_SUSP;
            stb.setUnavail = 1'b1;
          end
        end
      end
      PH_BUF: begin
        if (bufErr) begin
          nextPhase    = PH_STOP;
          stb.setFatal = 1'b1;
        end else if (bufAck) begin
          nextPhase = PH_WB;
        end
      end
      PH_WB: begin
        if (busErr) begin
          nextPhase     = PH_STOP;
          stb.setFatal  = 1'b1;
          stb.errIsDesc = 1'b1;
        end else if (busAck) begin
          stb.advance = 1'b1;
          nextPhase   = stopNow ? PH_STOP : PH_FETCH;
        end
      end
      PH_SUSP: begin
        if (stopNow)         nextPhase = PH_STOP;
        else if (pollDemand) nextPhase = PH_FETCH;
      end
      default: nextPhase = PH_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_STOP;
      stopPend <= 1'b0;
    end else begin
      phase <= nextPhase;
      if (nextPhase == PH_STOP) stopPend <= 1'b0;
      else                      stopPend <= stopNow;
    end
  end

  assign busReq = (phase == PH_FETCH) || (phase == PH_WB);
  assign busWe  = (phase == PH_WB);
  assign bufReq = (phase == PH_BUF);

  always_comb begin
    case (phase)
      PH_STOP: runState = RUN_STOPPED;
      PH_SUSP: runState = RUN_SUSPENDED;
      default: runState = RUN_ACTIVE;
    endcase
  end

  // R11: an open request keeps its direction until answered
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busErr |=> busReq && $stable(busWe));

  // R9: any error response leaves the engine stopped
  assert_halt_on_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busErr) || (bufReq && bufErr) |=> runState == RUN_STOPPED);

  // R6: a start pulse does not disturb a suspended engine
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    runState == RUN_SUSPENDED && startPulse && !pollDemand && !stopNow
    |=> runState == RUN_SUSPENDED);

  // R3: a suspended engine issues no traffic
  assert_susp_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(runState) == RUN_SUSPENDED && runState == RUN_SUSPENDED |-> !busReq && !bufReq);

endmodule

// File: rtl/rxRingPath.sv
module rxRingPath
  import rxRingPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReq,
  input  logic              busWe,
  input  logic              busAck,
  input  logic              busErr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              rdOwn,
  output logic [ADDR_W-1:0] curDesc,
  output logic              bufUnavail,
  output logic              fatalErr,
  output logic              errRead,
  output logic              errDesc
);

  localparam int OWN_POS = DATA_W - 1;
  localparam int END_POS = DATA_W - 2;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_WORDS * (DATA_W / 8));

  logic [ADDR_W-1:0] baseReg, curAddr;
  logic [DATA_W-1:0] word0Reg;
  logic              unavailReg, fatalReg, eReadReg, eDescReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      curAddr  <= '0;
      word0Reg <= '0;
    end else begin
      if (stb.loadBase) begin
        baseReg <= baseAddr;
        curAddr <= baseAddr;
      end else if (stb.advance) begin
        curAddr <= word0Reg[END_POS] ? baseReg : curAddr + STRIDE;
      end
      if (stb.latchWord) word0Reg <= busRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unavailReg <= 1'b0;
      fatalReg   <= 1'b0;
      eReadReg   <= 1'b0;
      eDescReg   <= 1'b0;
    end else begin
      if (stb.setUnavail)     unavailReg <= 1'b1;
      else if (stb.clrStatus) unavailReg <= 1'b0;
      if (stb.setFatal) begin
        fatalReg <= 1'b1;
        eReadReg <= stb.errIsRead;
        eDescReg <= stb.errIsDesc;
      end else if (stb.clrStatus) begin
        fatalReg <= 1'b0;
        eReadReg <= 1'b0;
        eDescReg <= 1'b0;
      end
    end
  end

  always_comb begin
    busWdata          = word0Reg;
    busWdata[OWN_POS] = 1'b0;
  end

  assign busAddr    = curAddr;
  assign rdOwn      = busRdata[OWN_POS];
  assign curDesc    = curAddr;
  assign bufUnavail = unavailReg;
  assign fatalErr   = fatalReg;
  assign errRead    = fatalReg & eReadReg;
  assign errDesc    = fatalReg & eDescReg;

  // R11: the address of an open request does not move
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busErr |=> $stable(busAddr));

  // R4: a writeback never claims ownership back
  assert_wb_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWe |-> !busWdata[OWN_POS]);

  // R10: error type flags hold while the fatal flag stays set
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr && !stb.setFatal && !stb.clrStatus |=> fatalErr && $stable({errRead, errDesc}));

  // R9: a fatal strobe always shows on the status flag
  assert_fatal_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFatal |=> fatalErr);

endmodule

// File: rtl/rxRingDma.sv
module rxRingDma
  import rxRingPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              pollDemand,
  input  logic              baseWr,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              stsClr,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  input  logic              busErr,
  output logic              bufReq,
  input  logic              bufAck,
  input  logic              bufErr,
  output logic [1:0]        runState,
  output logic [ADDR_W-1:0] curDesc,
  output logic              bufUnavail,
  output logic              fatalErr,
  output logic              errRead,
  output logic              errDesc
);

  rxStrobe_t stb;
  logic      rdOwn;

  rxRingCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .pollDemand (pollDemand),
    .baseWr     (baseWr),
    .stsClr     (stsClr),
    .busAck     (busAck),
    .busErr     (busErr),
    .rdOwn      (rdOwn),
    .bufAck     (bufAck),
    .bufErr     (bufErr),
    .busReq     (busReq),
    .busWe      (busWe),
    .bufReq     (bufReq),
    .runState   (runState),
    .stb        (stb)
  );

  rxRingPath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .DESC_WORDS (DESC_WORDS)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .baseAddr   (baseAddr),
    .busRdata   (busRdata),
    .busReq     (busReq),
    .busWe      (busWe),
    .busAck     (busAck),
    .busErr     (busErr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .rdOwn      (rdOwn),
    .curDesc    (curDesc),
    .bufUnavail (bufUnavail),
    .fatalErr   (fatalErr),
    .errRead    (errRead),
    .errDesc    (errDesc)
  );

endmodule

// File: tb/rxRingDma_test.sv
module rxRingDma_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 0, stopPulse = 0, pollDemand = 0, baseWr = 0, stsClr = 0;
  logic [31:0] baseAddr = '0;
  logic        busReq, busWe, bufReq;
  logic [31:0] busAddr, busWdata, curDesc;
  logic [31:0] busRdata = '0;
  logic        busAck = 0, busErr = 0, bufAck = 0, bufErr = 0;
  logic [1:0]  runState;
  logic        bufUnavail, fatalErr, errRead, errDesc;

  rxRingDma uut (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nErrors = 0, cycles = 0;
  logic [31:0] mem [16];
  logic [31:0] model [16];
  bit injFetchErr = 0, injWbErr = 0, injBufErr = 0;
  int busWait = 0, bufWait = 0;

  function automatic int idxOf(input logic [31:0] a);
    return int'((a - 32'h100) >> 4) & 15;
  endfunction

  // walks the model ring from a slot, releasing owned entries; returns suspend slot
  function automatic int walkRing(input int startIdx);
    int i = startIdx;
    for (int n = 0; n < 40; n++) begin
      if (!model[i][31]) break;
      model[i][31] = 1'b0;
      i = model[i][30] ? 0 : (i + 1) % 16;
    end
    return i;
  endfunction

  // bus and buffer responders
  always @(negedge clk) begin
    bit prevBus, prevBuf;
    prevBus = busAck | busErr;
    prevBuf = bufAck | bufErr;
    busAck = 0; busErr = 0; bufAck = 0; bufErr = 0;
    if (rstN && busReq && !prevBus) begin
      if (busWait > 0) busWait--;
      else begin
        busWait = $urandom % 3;
        if (busWe) begin
          if (injWbErr) begin busErr = 1; injWbErr = 0; end
          else begin mem[idxOf(busAddr)] = busWdata; busAck = 1; end
        end else begin
          if (injFetchErr) begin busErr = 1; injFetchErr = 0; end
          else begin busRdata = mem[idxOf(busAddr)]; busAck = 1; end
        end
      end
    end
    if (rstN && bufReq && !prevBuf) begin
      if (bufWait > 0) bufWait--;
      else begin
        bufWait = $urandom % 3;
        if (injBufErr) begin bufErr = 1; injBufErr = 0; end
        else bufAck = 1;
      end
    end
  end

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulseSig(input int which);
    @(negedge clk);
    case (which)
      0: startPulse = 1; 1: stopPulse = 1; 2: pollDemand = 1; 3: baseWr = 1; default: stsClr = 1;
    endcase
    @(negedge clk);
    startPulse = 0; stopPulse = 0; pollDemand = 0; baseWr = 0; stsClr = 0;
  endtask

  task automatic waitState(input logic [1:0] tgt, input string tag);
    int n = 0;
    while (runState !== tgt && n < 2000) begin @(negedge clk); n++; end
    chkEq(tag, 32'(runState), 32'(tgt));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nErrors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int curIdx, expIdx, bad;
    bit wasStopped;
    void'($urandom(32'd20241));
    for (int s = 0; s < 16; s++) mem[s] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 runState", 32'(runState), 0);
    chkEq("R1 requests", {30'd0, busReq, bufReq}, 0);
    chkEq("R1 flags", {28'd0, bufUnavail, fatalErr, errRead, errDesc}, 0);

    // R7 base load while stopped, R2 first fetch at base
    baseAddr = 32'h100; pulseSig(3);
    chkEq("R7 base load", curDesc, 32'h100);
    for (int s = 0; s < 3; s++) mem[s] = 32'h8000_0000 | (32'h11 * s);
    mem[3] = 32'h0000_0333;
    pulseSig(0);
    chkEq("R2 running", 32'(runState), 1);
    chkEq("R2 fetch addr", busAddr, 32'h100);
    chkEq("R2 fetch read", {31'd0, busWe}, 0);
    waitState(2, "R3 suspend");
    chkEq("R3 unavail", {31'd0, bufUnavail}, 1);
    chkEq("R4 position", curDesc, 32'h130);
    for (int s = 0; s < 3; s++) chkEq("R4 writeback", mem[s], 32'h11 * s);

    // R6 start ignored while suspended, R7 base write ignored
    baseAddr = 32'h180; pulseSig(3);
    pulseSig(0);
    repeat (5) @(negedge clk);
    chkEq("R6 still suspended", 32'(runState), 2);
    chkEq("R3 no request", {30'd0, busReq, bufReq}, 0);
    chkEq("R7 base ignored", curDesc, 32'h130);

    // R8 poll and R4 ring-end wrap
    mem[3] = 32'h8000_0333; mem[4] = 32'hC000_0444;
    pulseSig(2);
    waitState(2, "R8 resuspend");
    chkEq("R4 wrap to base", curDesc, 32'h100);
    chkEq("R4 end writeback", mem[4], 32'h4000_0444);

    // R5 stop while suspended, then base load and retention
    pulseSig(1);
    chkEq("R5 stop from suspend", 32'(runState), 0);
    chkEq("R5 pos kept", curDesc, 32'h100);
    baseAddr = 32'h100; pulseSig(3);
    mem[0] = 32'h8000_0aaa; mem[1] = 32'h8000_0bbb; mem[2] = 32'h8000_0ccc;
    pulseSig(0); pulseSig(1);
    waitState(0, "R5 stop at boundary");
    chkEq("R5 pos after stop", curDesc, 32'h110);
    chkEq("R5 next untouched", mem[1], 32'h8000_0bbb);
    pulseSig(0);
    chkEq("R2 resume addr", busAddr, 32'h110);
    waitState(2, "R5 resume suspend");
    chkEq("R5 resume pos", curDesc, 32'h130);

    // R9 error classification, R10 clearing
    pulseSig(1);
    mem[3] = 32'h8000_0333;
    injFetchErr = 1; pulseSig(0);
    waitState(0, "R9 fetch err stop");
    chkEq("R9 fetch err type", {29'd0, fatalErr, errRead, errDesc}, 3'b111);
    chkEq("R9 pos on err", curDesc, 32'h130);
    pulseSig(4);
    chkEq("R10 cleared", {28'd0, bufUnavail, fatalErr, errRead, errDesc}, 0);
    injBufErr = 1; pulseSig(0);
    waitState(0, "R9 buf err stop");
    chkEq("R9 buf err type", {29'd0, fatalErr, errRead, errDesc}, 3'b100);
    chkEq("R9 buf err owned", mem[3], 32'h8000_0333);
    pulseSig(4);
    injWbErr = 1; pulseSig(0);
    waitState(0, "R9 wb err stop");
    chkEq("R9 wb err type", {29'd0, fatalErr, errRead, errDesc}, 3'b101);
    chkEq("R9 wb err owned", mem[3], 32'h8000_0333);
    chkEq("R9 wb err pos", curDesc, 32'h130);
    repeat (3) @(negedge clk);
    chkEq("R10 type held", {29'd0, fatalErr, errRead, errDesc}, 3'b101);
    pulseSig(4);
    pulseSig(0);
    waitState(2, "R9 recover");
    chkEq("R9 recover pos", curDesc, 32'h140);

    // random ring contents with polls and stop/start
    curIdx = 4; wasStopped = 0;
    for (int it = 0; it < 24; it++) begin
      pulseSig(4);
      for (int s = 0; s < 16; s++) begin
        logic [31:0] w = $urandom;
        w[31] = ($urandom % 4) != 0;
        w[30] = (s == 15);
        mem[s] = w; model[s] = w;
      end
      expIdx = walkRing(curIdx);
      pulseSig(wasStopped ? 0 : 2);
      waitState(2, "R8 random suspend");
      chkEq("R4 random pos", curDesc, 32'h100 + 32'(expIdx) * 16);
      chkEq("R3 random unavail", {31'd0, bufUnavail}, 1);
      bad = 0;
      for (int s = 0; s < 16; s++) if (mem[s] !== model[s]) bad++;
      chkEq("R4 random ring", 32'(bad), 0);
      curIdx = expIdx;
      wasStopped = (it % 3 == 1);
      if (wasStopped) begin
        pulseSig(1);
        chkEq("R5 random stop", 32'(runState), 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule